// File: doc/BRIEF.md
# Target Initial-Latency Wait-State Controller

This block runs on the user side of a parallel-bus target and sets how many wait states come before the first data phase of a transaction. The transaction starts when the initiator's frame and the address-valid strobe are both seen while the block is idle. On that edge a down-counter takes a programmed value, which is the wanted number of wait states plus three. The counter then steps down once per clock. When it reaches three or less, the block raises a ready request and a terminate request in the same cycle.

A small response sequencer turns those requests into the bus-side handshake. Device-select comes up one clock after the start edge (medium decode). Target-ready and stop come up together on the edge after the requests are sampled, so exactly one word moves. Stop is then held for one more clock with target-ready low. Device-select drops once the initiator has released frame. All signals are active high. The initiator is taken to be ready on every data phase.

Top module: `tgt_wait_ctrl`

## Requirements
- R1: After reset, trdy, stop, devsel, rdy_req and term_req are all low, and the latency counter holds zero.
- R2: A transaction starts only on an edge where frame and addr_vld are both high while the block is idle. devsel rises on the next edge and stays high through the wait and data phases.
- R3: On the start edge the counter loads burst_wait. After that it goes down by one on each edge and stops at zero without wrapping.
- R4: rdy_req and term_req are driven combinationally and are always equal. They are high exactly when the counter is at three or less and the transaction is still in its decode or wait phase. Otherwise, including when idle and during the data phase, they are low.
- R5: trdy and stop rise together on the edge after the requests are sampled high. The number of clocks from devsel rising to trdy rising is burst_wait minus three, or zero when burst_wait is three or less.
- R6: trdy is high for exactly one clock, and exactly one data word is transferred per transaction.
- R7: On the clock after the transfer, stop stays high, trdy is low and devsel is still high.
- R8: While frame stays high after the transfer, the block holds stop and devsel high with trdy low. On the first edge that samples frame low in that phase, devsel and stop drop and the block returns to idle.
- R9: addr_vld or a new burst_wait value seen during an active transaction is ignored. The counter is not reloaded and the latency does not change.
- R10: addr_vld with frame low starts nothing. All outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| frame | input | 1 | Initiator frame, high while the transaction is in progress |
| addr_vld | input | 1 | Address-valid strobe from the bus interface |
| burst_wait | input | TMR_W | Programmed latency, equal to wait states plus three |
| rdy_req | output | 1 | Ready request (combinational) |
| term_req | output | 1 | Terminate request (combinational) |
| trdy | output | 1 | Target ready, high for the one data phase |
| stop | output | 1 | Stop, high in the data phase and the clock after it |
| devsel | output | 1 | Device select |

## Verification
A counter that loads or steps wrongly shows up directly at trdy. The bench counts devsel-to-trdy clocks for each programmed value, so any off-by-one appears on the first transaction that uses that value. A sequencer stuck in the wrong phase shows up as a second trdy pulse, a stop that is missing in the clock after the transfer, or a devsel that outlives frame. Each of these is visible within one or two clocks of the data phase. A request mask that leaks shows up as rdy_req high in idle or during the data phase, in the same cycle it occurs.

// File: rtl/tgt_wait_pkg.sv
// Shared definitions for the target initial-latency controller.
// Assumes: the latency offset is the fixed gap between the programmed value
// and the number of wait states actually inserted.
package tgt_wait_pkg;

    localparam int LAT_OFFSET = 3;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_DECODE = 3'd1,
        SEQ_WAIT   = 3'd2,
        SEQ_DATA   = 3'd3,
        SEQ_HOLD   = 3'd4
    } seq_st_t;

endpackage

// File: rtl/tgt_lat_timer.sv
// Latency down-counter with the combinational ready/terminate request logic.
// Loads on start, decrements each clock, saturates at zero. Requests are
// raised together while the count is at or below FIRE_LVL and arm is high.
// Assumes: arm is high only in the decode and wait phases.
module tgt_lat_timer #(
    parameter int TMR_W    = 4,
    parameter int FIRE_LVL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             arm,
    output logic             rdy_req,
    output logic             term_req
);

    localparam logic [TMR_W-1:0] FIRE_V = TMR_W'(FIRE_LVL);

    logic [TMR_W-1:0] tmr_q;
    logic             fire;

    // Load on start, otherwise step down toward zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_q <= '0;
        else if (load)
            tmr_q <= load_val;
        else if (tmr_q != '0)
            tmr_q <= tmr_q - 1'b1;
    end

    // Both requests come from one compare, so they always move together.
    always_comb begin
        fire     = arm && (tmr_q <= FIRE_V);
        rdy_req  = fire;
        term_req = fire;
    end

    // R3
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tmr_q != '0) |=> (tmr_q < $past(tmr_q)));

    // R3
    tmr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tmr_q == '0) |=> (tmr_q == '0));

    // R4
    req_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm) |-> (!rdy_req && !term_req));

endmodule

// File: rtl/tgt_resp_seq.sv
// Response sequencer: turns ready/terminate requests into the bus-side
// device-select, target-ready and stop, ending the burst with a single
// disconnect-with-data transfer.
// Assumes: the initiator is ready on every data phase and releases frame
// after it has seen stop.
module tgt_resp_seq
    import tgt_wait_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame,
    input  logic addr_vld,
    input  logic rdy_req,
    input  logic term_req,
    output logic start,
    output logic arm,
    output logic trdy,
    output logic stop,
    output logic devsel
);

    seq_st_t st_q, st_d;

    // Start is accepted only from idle, with frame and the strobe both high.
    always_comb start = (st_q == SEQ_IDLE) && frame && addr_vld;

    // Next-state selection for the response phases.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:   if (start) st_d = SEQ_DECODE;
            SEQ_DECODE: st_d = (rdy_req && term_req) ? SEQ_DATA : SEQ_WAIT;
            SEQ_WAIT:   if (rdy_req && term_req) st_d = SEQ_DATA;
            SEQ_DATA:   st_d = SEQ_HOLD;
            SEQ_HOLD:   if (!frame) st_d = SEQ_IDLE;
            default:    st_d = SEQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= SEQ_IDLE;
        else
            st_q <= st_d;
    end

    // Bus-side outputs decoded from the phase register.
    always_comb begin
        arm    = (st_q == SEQ_DECODE) || (st_q == SEQ_WAIT);
        trdy   = (st_q == SEQ_DATA);
        stop   = (st_q == SEQ_DATA) || (st_q == SEQ_HOLD);
        devsel = (st_q == SEQ_WAIT) || (st_q == SEQ_DATA) || (st_q == SEQ_HOLD);
    end

    // R6
    one_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trdy |=> !trdy);

    // R5
    trdy_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trdy |-> stop);

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy) |-> (stop && devsel));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !trdy && !frame) |=> (!devsel && !stop));

    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel) |-> (!trdy && !stop));

endmodule

// File: rtl/tgt_wait_ctrl.sv
// Top of the target initial-latency wait-state controller: ties the latency
// counter to the response sequencer.
// Assumes: burst_wait is stable on the start edge; values below the latency
// offset give zero wait states.
module tgt_wait_ctrl #(
    parameter int TMR_W    = 4,
    parameter int FIRE_LVL = tgt_wait_pkg::LAT_OFFSET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame,
    input  logic             addr_vld,
    input  logic [TMR_W-1:0] burst_wait,
    output logic             rdy_req,
    output logic             term_req,
    output logic             trdy,
    output logic             stop,
    output logic             devsel
);

    logic start;
    logic arm;

    tgt_lat_timer #(
        .TMR_W    (TMR_W),
        .FIRE_LVL (FIRE_LVL)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (burst_wait),
        .arm      (arm),
        .rdy_req  (rdy_req),
        .term_req (term_req)
    );

    tgt_resp_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame    (frame),
        .addr_vld (addr_vld),
        .rdy_req  (rdy_req),
        .term_req (term_req),
        .start    (start),
        .arm      (arm),
        .trdy     (trdy),
        .stop     (stop),
        .devsel   (devsel)
    );

    // R5
    trdy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trdy) |-> $past(rdy_req && term_req));

    // R2
    devsel_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel) |-> $past(start, 2));

    // R4
    req_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_req == term_req);

endmodule

// File: tb/tgt_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module tgt_wait_ctrl_tb_top;

    localparam int TMR_W = 4;
    localparam int NVEC  = 6;
    localparam int BW_TAB  [NVEC] = '{3, 4, 5, 8, 1, 15};
    localparam int EXP_TAB [NVEC] = '{0, 1, 2, 5, 0, 12};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame = 1'b0;
    logic             addr_vld = 1'b0;
    logic [TMR_W-1:0] burst_wait = '0;
    logic             rdy_req, term_req, trdy, stop, devsel;

    int n_chk = 0;
    int n_fail = 0;
    int n_xfer = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tgt_wait_ctrl #(.TMR_W(TMR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame(frame), .addr_vld(addr_vld),
        .burst_wait(burst_wait), .rdy_req(rdy_req), .term_req(term_req),
        .trdy(trdy), .stop(stop), .devsel(devsel)
    );

    // Count transferred words at the sampling point.
    always @(negedge clk) if (rst_n && trdy) n_xfer++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic all_low(input string tag);
        chk(!trdy && !stop && !devsel, tag, {trdy, stop, devsel}, 0);
        chk(!rdy_req && !term_req, tag, {rdy_req, term_req}, 0);
    endtask

    // One transaction; poke re-strobes addr_vld mid-wait, hold keeps frame up.
    task automatic run_txn(input int bw, input int n, input bit poke, input int hold);
        int e;
        int x0;
        x0 = n_xfer;
        @(negedge clk);
        frame = 1'b1; addr_vld = 1'b1; burst_wait = TMR_W'(bw);
        @(negedge clk);
        addr_vld = 1'b0;
        e = 0;
        while (!trdy && e < 100) begin
            chk(rdy_req == (e >= n), "R4 req level", rdy_req, e >= n);
            chk(term_req == rdy_req, "R4 term pairs ready", term_req, rdy_req);
            chk(devsel == (e >= 1), "R2 devsel timing", devsel, e >= 1);
            addr_vld = poke && (e == 1);
            if (poke && e == 1) burst_wait = '1;  // R9 stimulus
            e++;
            @(negedge clk);
        end
        addr_vld = 1'b0;
        chk(e == n + 1, "R5 latency R9", e - 1, n);
        chk(stop && devsel, "R5 stop with trdy", {stop, devsel}, 3);
        chk(!rdy_req, "R4 masked in data", rdy_req, 0);
        if (hold == 0) frame = 1'b0;
        @(negedge clk);
        chk(!trdy && stop && devsel, "R7 stop hold", {trdy, stop, devsel}, 3);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk(!trdy && stop && devsel, "R8 hold while frame", {trdy, stop, devsel}, 3);
        end
        frame = 1'b0;
        if (hold > 0) @(negedge clk);
        @(negedge clk);
        all_low("R8 release");
        chk(n_xfer - x0 == 1, "R6 one transfer", n_xfer - x0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        all_low("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        all_low("R1 after reset");

        for (int i = 0; i < NVEC; i++)
            run_txn(BW_TAB[i], EXP_TAB[i], 1'b0, 0);

        // R10: strobe without frame
        addr_vld = 1'b1; burst_wait = 4'd3;
        repeat (4) begin
            @(negedge clk);
            all_low("R10 no frame");
        end
        addr_vld = 1'b0;

        run_txn(8, 5, 1'b1, 0);   // R9
        run_txn(5, 2, 1'b0, 3);   // R8
        run_txn(3, 0, 1'b0, 2);   // R8 with zero wait

        // R3: counter ran to zero and stays there; a new start still loads fully
        repeat (20) @(negedge clk);
        all_low("R3 idle after long run");
        run_txn(6, 3, 1'b0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule